// File: doc/BRIEF.md
# Host Notify Receiver

This block sits inside a bus host and listens to the two-wire management bus as a slave. Devices that act as bus masters use it to report an event to the host. They send a short write frame to the host's own address. The byte in the position of a command code carries the sender's address, and the two bytes after it carry a 16-bit word, low byte first. The receiver acknowledges each byte of a frame meant for it. When the frame closes correctly it turns the frame into an event, not a register write.

Clock and data come in as sampled levels. The block drives only an open-drain pull-down enable, and only for acknowledge bits. When a frame completes, the block gives a one-cycle strobe together with the sender's 7-bit address and the word. It also sets a pending flag that stays set until the clear input is pulsed. If a second event arrives while the flag is still set, an overrun flag is raised and the newer values replace the held ones.

Top module: `hn_notify_rx`

## Requirements
- R1: After reset, notify_pulse, notify_pend, notify_ovr and sda_oe are 0, and notify_dev and notify_data are 0.
- R2: After a start, an address byte equal to {HOST_ADDR, 1'b0} (HOST_ADDR defaults to 7'h08, so the byte is 8'h10, sent MSB first) is acknowledged: sda_oe pulls the line low for the ninth clock.
- R3: In an accepted frame, each of the first three bytes after the address byte is acknowledged.
- R4: A frame whose address byte carries another address, or whose lowest bit (read) is 1, gets no acknowledge on any byte. It leaves the strobe, the held values and both flags unchanged.
- R5: A stop that follows exactly three acknowledged bytes raises notify_pulse for exactly one clock cycle. At the same time notify_dev is set to bits [7:1] of the first byte and notify_data to {third byte, second byte}.
- R6: A frame that stops after fewer than three bytes, or that carries a fourth byte, is discarded. The fourth byte is not acknowledged, and there is no strobe and no change to the held values or flags.
- R7: A notify event sets notify_pend. notify_pend stays set until clr_i is high for a cycle, and clr_i clears both notify_pend and notify_ovr.
- R8: A notify event that arrives while notify_pend is set raises notify_ovr, and the newer address and word replace the held ones.
- R9: A repeated start in the middle of a frame drops the partial frame and restarts address matching. A complete frame that follows is reported normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level as seen on the pin |
| sda_i | input | 1 | Bus data level as seen on the pin |
| clr_i | input | 1 | Clears the pending and overrun flags |
| sda_oe | output | 1 | Pull the data line low (acknowledge) |
| notify_pulse | output | 1 | One-cycle strobe for each accepted event |
| notify_dev | output | 7 | Address of the device that sent the last event |
| notify_data | output | 16 | Word of the last event |
| notify_pend | output | 1 | Event pending, held until cleared |
| notify_ovr | output | 1 | Event arrived while one was pending |

## Verification
The bench goes after the frame length. A parser that counts bytes loosely would report frames with zero, two or four payload bytes, or would acknowledge a fourth byte. It also targets frames addressed elsewhere and frames with the read bit set. A wrong address compare would acknowledge these frames and overwrite the held word. Back-to-back events without a clear check the overrun path: a design that kept the older values or never set the flag would show stale data. A repeated start sent after a partial payload shows whether stale byte counts survive into the next frame.

// File: rtl/hn_pkg.sv
package hn_pkg;
  // payload bytes after the address byte: sender address, word low, word high
  localparam int unsigned NOTIFY_BYTES = 3;
  localparam int unsigned CNT_W        = $clog2(NOTIFY_BYTES + 1);
  localparam int unsigned BIT_W        = 4;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_ACK,
    RX_DATA,
    RX_SKIP
  } rx_state_e;
endpackage

// File: rtl/hn_bus_sync.sv
module hn_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;
  logic scl_now, sda_now;

  assign scl_now = scl_sh[STAGES-1];
  assign sda_now = sda_sh[STAGES-1];

  // idle bus is high: reset to ones so no false edge appears at release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_now;
      sda_d  <= sda_now;
    end
  end

  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  assign start_det = scl_now & scl_d & sda_d & ~sda_now;
  assign stop_det  = scl_now & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/hn_frame_rx.sv
module hn_frame_rx
  import hn_pkg::*;
#(
  parameter logic [6:0] HOST_ADDR = 7'h08
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sda_lvl,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  output logic        sda_oe,
  output logic        frame_ok,
  output logic [6:0]  dev_addr,
  output logic [15:0] word
);
  localparam logic [BIT_W-1:0] BYTE_BITS = BIT_W'(8);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(NOTIFY_BYTES);

  rx_state_e        state_q, state_n;
  logic [BIT_W-1:0] bitcnt_q, bitcnt_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]       shift_q, shift_n;
  logic [6:0]       dev_q, dev_n;
  logic [7:0]       lo_q, lo_n, hi_q, hi_n;
  logic             oe_q, oe_n;
  logic             byte_done;

  assign byte_done = scl_fall && (bitcnt_q == BYTE_BITS);

  always_comb begin
    state_n  = state_q;
    bitcnt_n = bitcnt_q;
    cnt_n    = cnt_q;
    shift_n  = shift_q;
    dev_n    = dev_q;
    lo_n     = lo_q;
    hi_n     = hi_q;
    oe_n     = oe_q;
    frame_ok = 1'b0;
    if (start_det) begin
      state_n  = RX_ADDR;
      bitcnt_n = '0;
      cnt_n    = '0;
      oe_n     = 1'b0;
    end else if (stop_det) begin
      // the stop is preceded by one clock rise, hence bit count 0 or 1
      if (state_q == RX_DATA && cnt_q == LAST_CNT && bitcnt_q <= BIT_W'(1))
        frame_ok = 1'b1;
      state_n = RX_IDLE;
      oe_n    = 1'b0;
    end else begin
      unique case (state_q)
        RX_ADDR, RX_DATA: begin
          if (scl_rise && bitcnt_q < BYTE_BITS) begin
            shift_n  = {shift_q[6:0], sda_lvl};
            bitcnt_n = bitcnt_q + BIT_W'(1);
          end else if (byte_done) begin
            if (state_q == RX_ADDR) begin
              if (shift_q[7:1] == HOST_ADDR && !shift_q[0]) begin
                state_n = RX_ACK;
                oe_n    = 1'b1;
              end else begin
                state_n = RX_SKIP;
              end
            end else if (cnt_q < LAST_CNT) begin
              case (cnt_q)
                CNT_W'(0): dev_n = shift_q[7:1];
                CNT_W'(1): lo_n  = shift_q;
                default:   hi_n  = shift_q;
              endcase
              cnt_n   = cnt_q + CNT_W'(1);
              state_n = RX_ACK;
              oe_n    = 1'b1;
            end else begin
              state_n = RX_SKIP;
            end
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            oe_n     = 1'b0;
            state_n  = RX_DATA;
            bitcnt_n = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      bitcnt_q <= '0;
      cnt_q    <= '0;
      shift_q  <= '0;
      dev_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_n;
      bitcnt_q <= bitcnt_n;
      cnt_q    <= cnt_n;
      shift_q  <= shift_n;
      dev_q    <= dev_n;
      lo_q     <= lo_n;
      hi_q     <= hi_n;
      oe_q     <= oe_n;
    end
  end

  assign sda_oe   = oe_q;
  assign dev_addr = dev_q;
  assign word     = {hi_q, lo_q};
endmodule

// File: rtl/hn_event_reg.sv
module hn_event_reg #(
  parameter int unsigned DEV_W  = 7,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic [DEV_W-1:0]  dev_in,
  input  logic [DATA_W-1:0] word_in,
  input  logic              clr_i,
  output logic              pulse,
  output logic [DEV_W-1:0]  dev_out,
  output logic [DATA_W-1:0] data_out,
  output logic              pend,
  output logic              ovr
);
  logic pend_n, ovr_n, upd_en;
  logic [DEV_W-1:0]  dev_q;
  logic [DATA_W-1:0] data_q;
  logic pulse_q, pend_q, ovr_q;

  assign upd_en = frame_ok;

  always_comb begin
    pend_n = pend_q;
    ovr_n  = ovr_q;
    if (clr_i) begin
      pend_n = 1'b0;
      ovr_n  = 1'b0;
    end
    // a new event wins over a clear in the same cycle
    if (frame_ok) begin
      pend_n = 1'b1;
      ovr_n  = ovr_n | (pend_q & ~clr_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      pend_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      pulse_q <= frame_ok;
      pend_q  <= pend_n;
      ovr_q   <= ovr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q  <= '0;
      data_q <= '0;
    end else if (upd_en) begin
      dev_q  <= dev_in;
      data_q <= word_in;
    end
  end

  assign pulse    = pulse_q;
  assign dev_out  = dev_q;
  assign data_out = data_q;
  assign pend     = pend_q;
  assign ovr      = ovr_q;
endmodule

// File: rtl/hn_notify_rx.sv
module hn_notify_rx #(
  parameter logic [6:0]  HOST_ADDR   = 7'h08,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        clr_i,
  output logic        sda_oe,
  output logic        notify_pulse,
  output logic [6:0]  notify_dev,
  output logic [15:0] notify_data,
  output logic        notify_pend,
  output logic        notify_ovr
);
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic frame_ok;
  logic [6:0]  dev_addr;
  logic [15:0] word;

  hn_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  hn_frame_rx #(.HOST_ADDR(HOST_ADDR)) i_frame (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .frame_ok(frame_ok), .dev_addr(dev_addr), .word(word)
  );

  hn_event_reg #(.DEV_W(7), .DATA_W(16)) i_event (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .dev_in(dev_addr),
    .word_in(word), .clr_i(clr_i), .pulse(notify_pulse),
    .dev_out(notify_dev), .data_out(notify_data),
    .pend(notify_pend), .ovr(notify_ovr)
  );
endmodule

// File: rtl/hn_notify_rx_chk.sv
module hn_notify_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_i,
  input logic        notify_pulse,
  input logic [6:0]  notify_dev,
  input logic [15:0] notify_data,
  input logic        notify_pend,
  input logic        notify_ovr
);
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    notify_pulse |=> !notify_pulse);

  p_values_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !notify_pulse |-> ($stable(notify_data) && $stable(notify_dev)));

  p_pulse_sets_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    notify_pulse |-> notify_pend);

  p_pend_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_pend && !clr_i) |=> notify_pend);

  p_ovr_with_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    notify_ovr |-> notify_pend);
endmodule

bind hn_notify_rx hn_notify_rx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .notify_pulse(notify_pulse),
  .notify_dev(notify_dev), .notify_data(notify_data),
  .notify_pend(notify_pend), .notify_ovr(notify_ovr)
);

// File: tb/test_hn_notify_rx.sv
`timescale 1ns/1ps
module test_hn_notify_rx;
  localparam int H = 8;            // clocks per half bus period
  localparam int WATCHDOG = 150000;
  localparam int NVEC = 8;
  // {addr byte, byte count, b0, b1, b2, b3, event expected}
  localparam logic [43:0] VEC [NVEC] = '{
    {8'h10, 3'd3, 8'h5A, 8'h34, 8'h12, 8'h00, 1'b1},
    {8'h82, 3'd3, 8'h82, 8'hFF, 8'h00, 8'h00, 1'b0},
    {8'h10, 3'd3, 8'h83, 8'hFF, 8'h00, 8'h00, 1'b1},
    {8'h12, 3'd3, 8'h44, 8'h55, 8'h66, 8'h00, 1'b0},
    {8'h11, 3'd3, 8'h44, 8'h55, 8'h66, 8'h00, 1'b0},
    {8'h10, 3'd2, 8'h44, 8'h55, 8'h00, 8'h00, 1'b0},
    {8'h10, 3'd4, 8'h44, 8'h55, 8'h66, 8'h77, 1'b0},
    {8'h10, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic scl_drv, sda_drv, clr_i;
  logic sda_oe, notify_pulse, notify_pend, notify_ovr;
  logic [6:0]  notify_dev;
  logic [15:0] notify_data;
  logic sda_line;

  int total = 0, bad = 0, cyc = 0, pulses = 0, long_pulses = 0;
  logic prev_pulse = 1'b0;
  logic done = 1'b0;
  logic [43:0] e;
  logic [7:0]  db;
  logic ack, exp_ack, addr_ok;
  logic exp_pend, exp_ovr;
  logic [6:0]  exp_dev;
  logic [15:0] exp_data;
  int pulses_before;

  always #4 clk = ~clk;   // 125 MHz
  assign sda_line = sda_drv & ~sda_oe;

  hn_notify_rx i_hn_notify_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .clr_i(clr_i), .sda_oe(sda_oe), .notify_pulse(notify_pulse),
    .notify_dev(notify_dev), .notify_data(notify_data),
    .notify_pend(notify_pend), .notify_ovr(notify_ovr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (notify_pulse) pulses <= pulses + 1;
    if (notify_pulse && prev_pulse) long_pulses <= long_pulses + 1;
    prev_pulse <= notify_pulse;
    if (cyc == WATCHDOG && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // start or repeated start; works from idle or with the clock low
  task automatic bus_start();
    sda_drv = 1'b1; waitc(H);
    scl_drv = 1'b1; waitc(H);
    sda_drv = 1'b0; waitc(H);
    scl_drv = 1'b0; waitc(H);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; waitc(H);
    scl_drv = 1'b1; waitc(H);
    sda_drv = 1'b1; waitc(2 * H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic got_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; waitc(H);
      scl_drv = 1'b1; waitc(H);
      scl_drv = 1'b0;
    end
    sda_drv = 1'b1; waitc(H);
    scl_drv = 1'b1; waitc(H / 2);
    got_ack = ~sda_line;
    waitc(H / 2);
    scl_drv = 1'b0;
  endtask

  task automatic check_state(input string req);
    chk(req, "notify_pend", 32'(notify_pend), 32'(exp_pend));
    chk(req, "notify_ovr",  32'(notify_ovr),  32'(exp_ovr));
    chk(req, "notify_dev",  32'(notify_dev),  32'(exp_dev));
    chk(req, "notify_data", 32'(notify_data), 32'(exp_data));
  endtask

  task automatic pulse_clear();
    clr_i = 1'b1; waitc(1);
    clr_i = 1'b0; waitc(2);
    exp_pend = 1'b0;
    exp_ovr  = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1; clr_i = 1'b0;
    exp_pend = 1'b0; exp_ovr = 1'b0; exp_dev = '0; exp_data = '0;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    // R1 reset state
    chk("R1", "notify_pulse", 32'(notify_pulse), 32'd0);
    chk("R1", "sda_oe", 32'(sda_oe), 32'd0);
    check_state("R1");

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      e = VEC[v];
      pulses_before = pulses;
      addr_ok = (e[43:36] == 8'h10);
      bus_start();
      send_byte(e[43:36], ack);
      chk(addr_ok ? "R2" : "R4", "address ack", 32'(ack), 32'(addr_ok));
      for (int k = 0; k < int'(e[35:33]); k++) begin
        case (k)
          0: db = e[32:25];
          1: db = e[24:17];
          2: db = e[16:9];
          default: db = e[8:1];
        endcase
        send_byte(db, ack);
        exp_ack = addr_ok && (k < 3);
        chk(k < 3 ? (addr_ok ? "R3" : "R4") : "R6", "data ack",
            32'(ack), 32'(exp_ack));
      end
      bus_stop();
      waitc(10);
      if (e[0]) begin
        exp_ovr  = exp_ovr | exp_pend;
        exp_pend = 1'b1;
        exp_dev  = e[32:26];
        exp_data = {e[16:9], e[24:17]};
      end
      chk(e[0] ? "R5" : (addr_ok ? "R6" : "R4"), "strobe count",
          32'(pulses - pulses_before), 32'(e[0]));
      check_state(e[0] ? (exp_ovr ? "R8" : "R5") : (addr_ok ? "R6" : "R4"));
    end

    // R7 clear drops both flags, values held
    pulse_clear();
    check_state("R7");
    waitc(20);
    chk("R7", "pend stays clear", 32'(notify_pend), 32'd0);

    // R9 repeated start after partial payload, then a full frame
    pulses_before = pulses;
    bus_start();
    send_byte(8'h10, ack);
    send_byte(8'hAA, ack);
    send_byte(8'hBB, ack);
    bus_start();
    send_byte(8'h10, ack);
    chk("R9", "address ack after restart", 32'(ack), 32'd1);
    send_byte(8'h3C, ack);
    send_byte(8'hCD, ack);
    send_byte(8'hAB, ack);
    chk("R9", "third byte ack", 32'(ack), 32'd1);
    bus_stop();
    waitc(10);
    exp_pend = 1'b1; exp_dev = 7'h1E; exp_data = 16'hABCD;
    chk("R9", "strobe count", 32'(pulses - pulses_before), 32'd1);
    check_state("R9");

    // R8 second event without clear
    pulses_before = pulses;
    bus_start();
    send_byte(8'h10, ack);
    send_byte(8'h20, ack);
    send_byte(8'h01, ack);
    send_byte(8'h80, ack);
    bus_stop();
    waitc(10);
    exp_ovr = 1'b1; exp_dev = 7'h10; exp_data = 16'h8001;
    chk("R8", "strobe count", 32'(pulses - pulses_before), 32'd1);
    check_state("R8");

    chk("R5", "strobes longer than one cycle", 32'(long_pulses), 32'd0);
    chk("R1", "sda_oe idle at end", 32'(sda_oe), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule